// File: doc/BRIEF.md
# Bus-Cycle Acknowledge Sequencer

This block finishes processor bus cycles once external address decoding has claimed them. It runs at the bus clock and chooses one of four paths for each claimed cycle. The paths are a four-beat burst to synchronous burst SRAM, a fast single-beat SRAM access, a single-beat access to a slow Flash or I/O device, and an error termination. On each path it drives the active-low address acknowledge, transfer acknowledge and transfer error acknowledge back to the processor. It also drives the SRAM address strobe and the burst advance line.

Slow devices wait on an internal down-counter. The counter is reloaded from a cycle-time input on every idle clock, and it counts down on every clock of any other state. SRAM single beats bypass this counter, so a slow wait-state setting never delays them. Bursts use the burst advance line to run at 2-1-1-1. All outputs are decoded from the state register alone, so no input reaches an output through logic alone.

Top module: `bus_ack_fsm`

## Requirements
- R1: While `rst_n` is low the machine is idle, and all five outputs are high (deasserted). After release, nothing happens until a claim arrives.
- R2: A claim (`claim_n`=0) with `burst_n`=0, seen on a clock edge in idle, starts a burst. `ta_n` is low on the four following clocks. `aack_n` is low only on the fourth of them.
- R3: During a burst, `burst_adv_n` is low on the first three beats only. Whenever it is low, `ta_n` is low on the next clock as well.
- R4: A claim with `burst_n`=1 and `sram_cs_n`=0 is an SRAM single beat. One wait clock follows, then `ta_n` and `aack_n` are both low for exactly one clock, on the second clock after the claim edge. `cycle_time` has no effect on this path.
- R5: `sram_strobe_n` is low for exactly one clock. That clock is the first one after the claim edge of a burst or of an SRAM single beat. It is never low on any other path.
- R6: A claim with `burst_n`=1, `sram_cs_n`=1 and `err_req_n`=1 is a slow access. Let C be the value of `cycle_time` at the claim edge. `ta_n` and `aack_n` are both low for one clock, exactly C+2 clocks after the claim edge. Changing `cycle_time` after the claim has no effect.
- R7: A claim with `burst_n`=1, `sram_cs_n`=1 and `err_req_n`=0 is an error. On the next clock, `tea_n` and `aack_n` are low for one clock, and `ta_n` stays high.
- R8: When `claim_n` is high in idle, the other inputs have no effect. A claim that arrives while a cycle is in progress is ignored. The machine is idle again on the clock after the final acknowledge.
- R9: The claim types have a fixed priority: a burst ahead of an SRAM single beat, and an SRAM single beat ahead of an error request.
- R10: `ta_n` and `tea_n` are never low on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| claim_n | input | 1 | Cycle claimed by the address decoder, active low |
| burst_n | input | 1 | Burst transfer request, active low |
| sram_cs_n | input | 1 | SRAM chip select from the decoder, active low |
| err_req_n | input | 1 | Request to end the cycle with an error, active low |
| cycle_time | input | TW | Wait-state count for slow devices |
| aack_n | output | 1 | Address acknowledge, active low |
| ta_n | output | 1 | Transfer acknowledge, active low |
| tea_n | output | 1 | Transfer error acknowledge, active low |
| sram_strobe_n | output | 1 | SRAM address strobe, active low |
| burst_adv_n | output | 1 | SRAM burst address advance, active low |

## Verification
The cycle types are driven with mixed values on the inputs they should ignore. Bursts are driven with chip select deasserted and with an error request, and SRAM single beats with an error request and a large cycle time. This separates the priority order from a mere input decode, and it shows whether the wait counter leaks into the SRAM path. Slow accesses run at cycle times of 0, 1, 5 and 15, which places the acknowledge at the boundary values and in the middle of the range. Directed cases then cover reset in the middle of a burst, a claim that arrives while the machine is busy, and a change of cycle time during the countdown.

// File: rtl/bus_ack_fsm.sv
module bus_ack_fsm #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim_n,
  input  logic          burst_n,
  input  logic          sram_cs_n,
  input  logic          err_req_n,
  input  logic [TW-1:0] cycle_time,
  output logic          aack_n,
  output logic          ta_n,
  output logic          tea_n,
  output logic          sram_strobe_n,
  output logic          burst_adv_n
);

  typedef enum logic [3:0] {
    S_IDLE, S_BT1, S_BT2, S_BT3, S_BT4,
    S_SWAIT, S_SACK, S_CNT, S_DACK, S_ERR
  } st_t;

  st_t state, nxt;
  logic [TW-1:0] timer;

  always_comb begin
    nxt = S_IDLE;
    case (state)
      S_IDLE:
        if (!claim_n) begin
          if (!burst_n)        nxt = S_BT1;
          else if (!sram_cs_n) nxt = S_SWAIT;
          else if (!err_req_n) nxt = S_ERR;
          else                 nxt = S_CNT;
        end
      S_BT1:   nxt = S_BT2;
      S_BT2:   nxt = S_BT3;
      S_BT3:   nxt = S_BT4;
      S_SWAIT: nxt = S_SACK;
      S_CNT:   nxt = (timer == '0) ? S_DACK : S_CNT;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      timer <= '0;
    end else begin
      state <= nxt;
      timer <= (state == S_IDLE) ? cycle_time : timer - 1'b1;
    end

  assign ta_n          = !(state inside {S_BT1, S_BT2, S_BT3, S_BT4, S_SACK, S_DACK});
  assign aack_n        = !(state inside {S_BT4, S_SACK, S_DACK, S_ERR});
  assign tea_n         = !(state == S_ERR);
  assign sram_strobe_n = !(state inside {S_BT1, S_SWAIT});
  assign burst_adv_n   = !(state inside {S_BT1, S_BT2, S_BT3});

endmodule

module bus_ack_fsm_chk (
  input logic clk,
  input logic rst_n,
  input logic in_idle,
  input logic claim_n,
  input logic burst_n,
  input logic sram_cs_n,
  input logic err_req_n,
  input logic aack_n,
  input logic ta_n,
  input logic tea_n,
  input logic sram_strobe_n,
  input logic burst_adv_n
);

  p_burst_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !claim_n && !burst_n |=> !ta_n && !burst_adv_n && aack_n);

  p_adv_then_ta_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_adv_n |=> !ta_n);

  p_sram_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !claim_n && burst_n && !sram_cs_n |=> ta_n ##1 (!ta_n && !aack_n));

  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_strobe_n |=> sram_strobe_n);

  p_error_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !claim_n && burst_n && sram_cs_n && !err_req_n |=> !tea_n && !aack_n && ta_n);

  p_tea_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tea_n |=> tea_n);

  p_no_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && claim_n |=> ta_n && tea_n && aack_n && sram_strobe_n);

  p_ta_tea_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ta_n && !tea_n));

endmodule

bind bus_ack_fsm bus_ack_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_idle(state == S_IDLE),
  .claim_n(claim_n), .burst_n(burst_n), .sram_cs_n(sram_cs_n), .err_req_n(err_req_n),
  .aack_n(aack_n), .ta_n(ta_n), .tea_n(tea_n),
  .sram_strobe_n(sram_strobe_n), .burst_adv_n(burst_adv_n)
);

// File: tb/bus_ack_fsm_tb.sv
`timescale 1ns/1ps
module bus_ack_fsm_tb;
  localparam int L = 18;
  localparam int NV = 11;
  // kind: 0 none, 1 burst, 2 sram single, 3 slow, 4 error
  // entry: {kind[2:0], claim_n, burst_n, sram_cs_n, err_req_n, cycle_time[3:0]}
  localparam logic [10:0] VEC [NV] = '{
    {3'd1, 4'b0010, 4'd7},
    {3'd1, 4'b0010, 4'd3},
    {3'd1, 4'b0000, 4'd15},
    {3'd2, 4'b0100, 4'd9},
    {3'd2, 4'b0101, 4'd0},
    {3'd3, 4'b0111, 4'd0},
    {3'd3, 4'b0111, 4'd1},
    {3'd3, 4'b0111, 4'd5},
    {3'd3, 4'b0111, 4'd15},
    {3'd4, 4'b0110, 4'd4},
    {3'd0, 4'b1000, 4'd2}
  };

  logic clk = 0, rst_n = 0;
  logic claim_n = 1, burst_n = 1, sram_cs_n = 1, err_req_n = 1;
  logic [3:0] cycle_time = 0;
  logic aack_n, ta_n, tea_n, sram_strobe_n, burst_adv_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bus_ack_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .claim_n(claim_n), .burst_n(burst_n),
    .sram_cs_n(sram_cs_n), .err_req_n(err_req_n), .cycle_time(cycle_time),
    .aack_n(aack_n), .ta_n(ta_n), .tea_n(tea_n),
    .sram_strobe_n(sram_strobe_n), .burst_adv_n(burst_adv_n)
  );

  // {aack_n, ta_n, tea_n, sram_strobe_n, burst_adv_n}
  function automatic logic [4:0] expect_out(int kind, int c, int k);
    logic a = 1, t = 1, e = 1, s = 1, b = 1;
    case (kind)
      1: begin t = !(k >= 1 && k <= 4); a = !(k == 4); b = !(k >= 1 && k <= 3); s = !(k == 1); end
      2: begin s = !(k == 1); t = !(k == 2); a = !(k == 2); end
      3: begin t = !(k == c + 2); a = !(k == c + 2); end
      4: begin e = !(k == 1); a = !(k == 1); end
      default: ;
    endcase
    return {a, t, e, s, b};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act = {aack_n, ta_n, tea_n, sram_strobe_n, burst_adv_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp);
    end
  endtask

  task automatic idle_inputs();
    claim_n = 1; burst_n = 1; sram_cs_n = 1; err_req_n = 1;
  endtask

  // inj: cycle at which a burst claim is pushed while busy; newct: cycle_time rewritten at cycle 1
  task automatic run(logic [10:0] v, string req, int inj, int newct);
    int kind = int'(v[10:8]);
    int c = int'(v[3:0]);
    {claim_n, burst_n, sram_cs_n, err_req_n} = v[7:4];
    cycle_time = v[3:0];
    @(posedge clk); @(negedge clk);
    for (int k = 1; k <= L; k++) begin
      check(req, expect_out(kind, c, k));
      idle_inputs();
      if (k == inj) begin claim_n = 0; burst_n = 0; end
      if (k == 1 && newct >= 0) cycle_time = 4'(newct);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 5'b11111);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    check("R1 idle after reset", 5'b11111);

    // table: R2 R3 R5 R9 bursts, R4 R5 R9 sram, R6 slow, R7 error, R8 no claim, R10 throughout
    for (int i = 0; i < NV; i++)
      run(VEC[i], "R2-R10 table", -1, -1);

    // R8: claim while busy ignored
    run({3'd3, 4'b0111, 4'd6}, "R8 busy claim", 3, -1);
    // R6: cycle_time change after claim ignored
    run({3'd3, 4'b0111, 4'd2}, "R6 ctime change", -1, 15);

    // R1: reset mid-burst
    claim_n = 0; burst_n = 0;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R1 burst beat1", expect_out(1, 0, 1));
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-burst", 5'b11111);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 quiet after reset", 5'b11111);
    run(VEC[0], "R2 after reset", -1, -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule